// File: doc/BRIEF.md
# Ring-Propagated Triangular Neighborhood Grid

This block produces, for every neuron of a self-organizing map laid out as a ROWS x COLS grid, a neighborhood strength value and an in-neighborhood flag around a chosen winning neuron. The winner is given by its row and column. It receives the programmed peak strength. Every other cell takes the largest of (neighbor strength minus steepness) over its grid neighbors, floored at zero. Each ring of cells around the winner therefore costs exactly one subtraction relative to the ring inside it. The result is a triangular profile, `max(0, peak - steepness * d)`, where `d` is the ring distance in the chosen topology.

The spreading is an unrolled chain of identical combinational stages, with one stage per ring, up to the largest ring count the grid can hold. Every cell is evaluated in parallel, so any radius up to the map size is covered. A one-cycle start pulse captures the whole result into output registers and raises a done strobe on the following cycle. A training controller lowers the peak and steepness between epochs. When the steepness is at or above the peak, only the winner is active.

Top module: `som_nbr_ring_top`

## Requirements
- R1: While reset is applied, and after it is released, every strength output is 0, every in-neighborhood flag is 0 and done is 0 until the first start.
- R2: A start sampled high at a rising clock edge loads all outputs at that edge, and done is high for exactly the following cycle. Done is low in every cycle not preceded by a start.
- R3: Without start, the outputs hold their last values, whatever the winner, steepness, peak and topology inputs do.
- R4: A winner cell inside the grid always outputs exactly the peak value, for any steepness and topology.
- R5: With topology code 0 (four neighbors: up, down, left, right), each cell outputs max(0, peak - steepness*d), where d is the Manhattan distance to the winner.
- R6: With topology code 1 (eight neighbors), d is the Chebyshev distance (the larger of the row and column offsets).
- R7: With topology code 2 (hexagonal), a cell has its left and right neighbors and the cells directly above and below it. It also has the diagonal cells above and below at column +1 on odd rows and at column -1 on even rows. d is the hop count in that graph.
- R8: Topology code 3 behaves exactly like code 0.
- R9: A cell's in-neighborhood flag is 1 exactly when its strength output is nonzero.
- R10: With steepness 0 and a nonzero peak, every cell outputs the peak. With steepness greater than or equal to the peak, only the winner is nonzero.
- R11: A winner row or column outside the grid yields all strengths 0 and all flags 0.
- R12: Cell (r, c) occupies index i = r*COLS + c: its strength sits at bits [i*5 +: 5] of the strength bus, and its flag at bit i of the flag bus. Strength, steepness and peak are 5-bit unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to evaluate and capture the neighborhood |
| win_row_i | input | RW (4) | Winner row |
| win_col_i | input | CW (4) | Winner column |
| steep_i | input | VW (5) | Strength drop per ring |
| peak_i | input | VW (5) | Strength assigned to the winner |
| topo_i | input | 2 | 0: four neighbors, 1: eight neighbors, 2: hexagonal, 3: as 0 |
| nbr_val_o | output | ROWS*COLS*VW (320) | Registered strength per cell |
| in_nbr_o | output | ROWS*COLS (64) | Registered in-neighborhood flag per cell |
| done_o | output | 1 | High for one cycle after a start |

## Verification
The same winner position at the map center is run through all four topology codes. The resulting rings show whether diagonals are reached, and whether the hexagonal odd-row and even-row offsets are applied in the right direction. Corner winners in each topology check that the chain stops cleanly at the grid edge and reaches the far corner over the full stage depth. Extreme steepness and peak pairs (zero steepness, steepness at or above the peak, zero peak) separate full-map coverage from a winner-only result and check the flag against zero values. An out-of-grid winner and input changes made without a start show that nothing leaks into the registered result.

// File: rtl/som_nbr_pkg.sv
package som_nbr_pkg;

  // Topology select; code 3 is not listed and falls back to four neighbors.
  typedef enum logic [1:0] {
    TOPO_RECT4 = 2'd0,
    TOPO_RECT8 = 2'd1,
    TOPO_HEX   = 2'd2
  } topo_e;

  // Neighbor slots per cell: N, S, E, W, NE, NW, SE, SW.
  localparam int NB_SLOTS = 8;

endpackage

// File: rtl/som_nbr_cell.sv
// One cell of one propagation stage: strongest decremented neighbor.
module som_nbr_cell #(
  parameter int VW = 5,
  parameter int NB = 8
) (
  input  logic [VW-1:0]    own_i,
  input  logic [NB*VW-1:0] nb_val_i,
  input  logic [NB-1:0]    nb_en_i,
  input  logic             is_win_i,
  input  logic [VW-1:0]    steep_i,
  input  logic [VW-1:0]    peak_i,
  output logic [VW-1:0]    nxt_o
);

  logic [VW-1:0] best;
  logic [VW-1:0] cand;
  logic [VW-1:0] nv;

  always_comb begin
    best = own_i;
    cand = '0;
    nv   = '0;
    for (int k = 0; k < NB; k++) begin
      nv   = nb_val_i[k*VW +: VW];
      cand = (nv > steep_i) ? (nv - steep_i) : '0;
      if (nb_en_i[k] && (cand > best)) begin
        best = cand;
      end
    end
    nxt_o = is_win_i ? peak_i : best;
  end

endmodule

// File: rtl/som_nbr_stage.sv
// One ring step across the whole grid: every cell looks at its neighbors.
module som_nbr_stage
  import som_nbr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int VW   = 5
) (
  input  logic [ROWS*COLS*VW-1:0] cur_i,
  input  logic [ROWS*COLS-1:0]    win_i,
  input  logic [VW-1:0]           steep_i,
  input  logic [VW-1:0]           peak_i,
  input  topo_e                   topo_i,
  output logic [ROWS*COLS*VW-1:0] nxt_o
);

  logic rect8;
  logic hex;
  assign rect8 = (topo_i == TOPO_RECT8);
  assign hex   = (topo_i == TOPO_HEX);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX  = r*COLS + c;
      localparam bit UP   = (r > 0);
      localparam bit DN   = (r < ROWS-1);
      localparam bit LF   = (c > 0);
      localparam bit RT   = (c < COLS-1);
      localparam bit ODD  = ((r % 2) == 1);
      localparam int I_N  = UP ? IDX - COLS : IDX;
      localparam int I_S  = DN ? IDX + COLS : IDX;
      localparam int I_E  = RT ? IDX + 1 : IDX;
      localparam int I_W  = LF ? IDX - 1 : IDX;
      localparam int I_NE = (UP && RT) ? IDX - COLS + 1 : IDX;
      localparam int I_NW = (UP && LF) ? IDX - COLS - 1 : IDX;
      localparam int I_SE = (DN && RT) ? IDX + COLS + 1 : IDX;
      localparam int I_SW = (DN && LF) ? IDX + COLS - 1 : IDX;

      logic                    diag_r;
      logic                    diag_l;
      logic [NB_SLOTS*VW-1:0]  nv;
      logic [NB_SLOTS-1:0]     ne;

      // Hex rows are offset: odd rows reach right-hand diagonals, even rows left.
      assign diag_r = rect8 || (hex && ODD);
      assign diag_l = rect8 || (hex && !ODD);

      assign nv = {cur_i[I_SW*VW +: VW], cur_i[I_SE*VW +: VW],
                   cur_i[I_NW*VW +: VW], cur_i[I_NE*VW +: VW],
                   cur_i[I_W*VW +: VW],  cur_i[I_E*VW +: VW],
                   cur_i[I_S*VW +: VW],  cur_i[I_N*VW +: VW]};

      assign ne = {(DN && LF) && diag_l, (DN && RT) && diag_r,
                   (UP && LF) && diag_l, (UP && RT) && diag_r,
                   LF, RT, DN, UP};

      som_nbr_cell #(
        .VW (VW),
        .NB (NB_SLOTS)
      ) u_cell (
        .own_i    (cur_i[IDX*VW +: VW]),
        .nb_val_i (nv),
        .nb_en_i  (ne),
        .is_win_i (win_i[IDX]),
        .steep_i  (steep_i),
        .peak_i   (peak_i),
        .nxt_o    (nxt_o[IDX*VW +: VW])
      );
    end
  end

endmodule

// File: rtl/som_nbr_grid.sv
// Unrolled chain of ring stages, enough to cross the whole grid.
module som_nbr_grid
  import som_nbr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int VW   = 5
) (
  input  logic [ROWS*COLS*VW-1:0] seed_i,
  input  logic [ROWS*COLS-1:0]    win_i,
  input  logic [VW-1:0]           steep_i,
  input  logic [VW-1:0]           peak_i,
  input  topo_e                   topo_i,
  output logic [ROWS*COLS*VW-1:0] val_o
);

  localparam int CELLS  = ROWS*COLS;
  localparam int STAGES = (ROWS + COLS > 2) ? (ROWS + COLS - 2) : 1;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [CELLS*VW-1:0] cur;
    logic [CELLS*VW-1:0] nxt;

    if (s == 0) begin : g_first
      assign cur = seed_i;
    end else begin : g_next
      assign cur = g_stg[s-1].nxt;
    end

    som_nbr_stage #(
      .ROWS (ROWS),
      .COLS (COLS),
      .VW   (VW)
    ) u_stage (
      .cur_i   (cur),
      .win_i   (win_i),
      .steep_i (steep_i),
      .peak_i  (peak_i),
      .topo_i  (topo_i),
      .nxt_o   (nxt)
    );
  end

  assign val_o = g_stg[STAGES-1].nxt;

endmodule

// File: rtl/som_nbr_ring_top.sv
module som_nbr_ring_top
  import som_nbr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int VW   = 5,
  parameter int RW   = $clog2(ROWS + 1),
  parameter int CW   = $clog2(COLS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [RW-1:0]           win_row_i,
  input  logic [CW-1:0]           win_col_i,
  input  logic [VW-1:0]           steep_i,
  input  logic [VW-1:0]           peak_i,
  input  logic [1:0]              topo_i,
  output logic [ROWS*COLS*VW-1:0] nbr_val_o,
  output logic [ROWS*COLS-1:0]    in_nbr_o,
  output logic                    done_o
);

  localparam int CELLS = ROWS*COLS;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  // Winner decode and stage-zero seed.
  logic [CELLS-1:0]    win_mask;
  logic [CELLS*VW-1:0] seed;
  logic [CELLS*VW-1:0] grid_val;

  for (genvar r = 0; r < ROWS; r++) begin : g_wr
    for (genvar c = 0; c < COLS; c++) begin : g_wc
      localparam int IDX = r*COLS + c;
      assign win_mask[IDX]          = (win_row_i == RW'(r)) && (win_col_i == CW'(c));
      assign seed[IDX*VW +: VW]     = win_mask[IDX] ? peak_i : '0;
    end
  end

  som_nbr_grid #(
    .ROWS (ROWS),
    .COLS (COLS),
    .VW   (VW)
  ) u_grid (
    .seed_i  (seed),
    .win_i   (win_mask),
    .steep_i (steep_i),
    .peak_i  (peak_i),
    .topo_i  (topo_e'(topo_i)),
    .val_o   (grid_val)
  );

  // Next state, then registers.
  logic [CELLS*VW-1:0] val_q, val_d;
  logic [CELLS-1:0]    flag_q, flag_d, flag_new;
  logic                done_q, done_d;

  for (genvar i = 0; i < CELLS; i++) begin : g_flag
    assign flag_new[i] = |grid_val[i*VW +: VW];
  end

  always_comb begin
    val_d  = val_q;
    flag_d = flag_q;
    if (start_i) begin
      val_d  = grid_val;
      flag_d = flag_new;
    end
    done_d = start_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      val_q  <= '0;
      flag_q <= '0;
      done_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      flag_q <= flag_d;
      done_q <= done_d;
    end
  end

  assign nbr_val_o = val_q;
  assign in_nbr_o  = flag_q;
  assign done_o    = done_q;

  // Checks on the registered result.
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_i |=> done_o);  // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !start_i |=> !done_o);  // R2
  AST_HOLD_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    !start_i |=> ($stable(nbr_val_o) && $stable(in_nbr_o)));  // R3
  AST_FULL_MAP_AT_ZERO_STEEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_i && (steep_i == '0) && (peak_i != '0) && (|win_mask)) |=> (&in_nbr_o));  // R10
  AST_OFF_GRID_EMPTY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_i && !(|win_mask)) |=> (in_nbr_o == '0));  // R11

  for (genvar i = 0; i < CELLS; i++) begin : g_ast
    AST_WINNER_PEAK: assert property (@(posedge clk) disable iff (!rst_int_n)
      (start_i && win_mask[i]) |=> (nbr_val_o[i*VW +: VW] == $past(peak_i)));  // R4
    AST_NEVER_ABOVE_PEAK: assert property (@(posedge clk) disable iff (!rst_int_n)
      start_i |=> (nbr_val_o[i*VW +: VW] <= $past(peak_i)));  // R5
  end

endmodule

// File: tb/sim_som_nbr_ring_top.sv
module sim_som_nbr_ring_top;

  localparam int  ROWS   = 8;
  localparam int  COLS   = 8;
  localparam int  VW     = 5;
  localparam int  RW     = $clog2(ROWS + 1);
  localparam int  CW     = $clog2(COLS + 1);
  localparam int  CELLS  = ROWS*COLS;
  localparam time TCLK   = 10ns;
  localparam int  WD_CYC = 20000;

  logic                clk;
  logic                rst_n;
  logic                start_i;
  logic [RW-1:0]       win_row_i;
  logic [CW-1:0]       win_col_i;
  logic [VW-1:0]       steep_i;
  logic [VW-1:0]       peak_i;
  logic [1:0]          topo_i;
  logic [CELLS*VW-1:0] nbr_val_o;
  logic [CELLS-1:0]    in_nbr_o;
  logic                done_o;

  som_nbr_ring_top #(
    .ROWS (ROWS),
    .COLS (COLS),
    .VW   (VW)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .win_row_i (win_row_i),
    .win_col_i (win_col_i),
    .steep_i   (steep_i),
    .peak_i    (peak_i),
    .topo_i    (topo_i),
    .nbr_val_o (nbr_val_o),
    .in_nbr_o  (in_nbr_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  typedef struct {
    logic [CELLS*VW-1:0] v;
    logic [CELLS-1:0]    f;
    string               tag;
  } exp_t;

  exp_t                q[$];
  int                  checks = 0;
  int                  errors = 0;
  logic [CELLS*VW-1:0] last_v;
  logic [CELLS-1:0]    last_f;

  task automatic check_val(input logic [CELLS*VW-1:0] act, input logic [CELLS*VW-1:0] exp,
                           input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s strengths: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_flag(input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp,
                            input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flags: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic int iabs(input int a);
    return (a < 0) ? -a : a;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Ring distance in the selected topology.
  function automatic int ring_dist(input int topo, input int r0, input int c0,
                                   input int r1, input int c1);
    int x0, x1, y0, y1;
    if (topo == 1) begin
      return imax(iabs(r1 - r0), iabs(c1 - c0));
    end else if (topo == 2) begin
      x0 = c0 - (r0 - (r0 % 2)) / 2;
      x1 = c1 - (r1 - (r1 % 2)) / 2;
      y0 = -x0 - r0;
      y1 = -x1 - r1;
      return imax(imax(iabs(x1 - x0), iabs(y1 - y0)), iabs(r1 - r0));
    end
    return iabs(r1 - r0) + iabs(c1 - c0);
  endfunction

  task automatic run_case(input int wr, input int wc, input int st, input int pk,
                          input int topo, input string tag);
    exp_t e;
    int   d, v;
    e.v   = '0;
    e.f   = '0;
    e.tag = tag;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (wr < ROWS && wc < COLS) begin
          d = ring_dist(topo, wr, wc, r, c);
          v = pk - st*d;
          if (v < 0) v = 0;
        end else begin
          v = 0;
        end
        e.v[(r*COLS + c)*VW +: VW] = VW'(v);
        e.f[r*COLS + c]            = (v != 0);
      end
    end
    @(negedge clk);
    win_row_i = RW'(wr);
    win_col_i = CW'(wc);
    steep_i   = VW'(st);
    peak_i    = VW'(pk);
    topo_i    = 2'(topo);
    start_i   = 1'b1;
    q.push_back(e);
    last_v = e.v;
    last_f = e.f;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor: compare each captured result against the queued expectation.
  always @(negedge clk) begin
    if (done_o === 1'b1) begin
      if (q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2 done without start: actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check_val(nbr_val_o, e.v, {e.tag, " R4 R12"});
        check_flag(in_nbr_o, e.f, {e.tag, " R9"});
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    start_i   = 1'b0;
    win_row_i = '0;
    win_col_i = '0;
    steep_i   = '0;
    peak_i    = '0;
    topo_i    = '0;
    repeat (3) @(negedge clk);
    check_val(nbr_val_o, '0, "R1 in reset");
    check_flag(in_nbr_o, '0, "R1 in reset");
    check_bit(done_o, 1'b0, "R1 done in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_val(nbr_val_o, '0, "R1 after release");
    check_bit(done_o, 1'b0, "R1 done after release");

    run_case(3, 4, 6, 31, 0, "R5 center four-neighbor");
    run_case(3, 4, 6, 31, 1, "R6 center eight-neighbor");
    run_case(3, 4, 6, 31, 2, "R7 hex odd-row winner");
    run_case(4, 2, 6, 31, 2, "R7 hex even-row winner");
    run_case(7, 0, 4, 31, 2, "R7 hex corner");
    run_case(3, 4, 6, 31, 3, "R8 code three");
    run_case(7, 7, 3, 31, 0, "R5 far corner");
    run_case(0, 0, 2, 31, 1, "R6 corner");
    run_case(0, 0, 0, 20, 0, "R10 zero steepness");
    run_case(5, 5, 31, 31, 1, "R10 steepness equals peak");
    run_case(2, 6, 12, 10, 2, "R10 steepness above peak");
    run_case(8, 3, 6, 31, 0, "R11 row off grid");
    run_case(2, 15, 6, 31, 1, "R11 column off grid");
    run_case(4, 4, 6, 0, 0, "R9 zero peak");
    run_case(1, 1, 1, 17, 2, "R7 hex shallow slope");

    // R3: change every input without start; outputs must keep the last result.
    @(negedge clk);
    win_row_i = 4'd0;
    win_col_i = 4'd0;
    steep_i   = 5'd0;
    peak_i    = 5'd31;
    topo_i    = 2'd1;
    repeat (3) @(negedge clk);
    check_val(nbr_val_o, last_v, "R3 hold strengths");
    check_flag(in_nbr_o, last_f, "R3 hold flags");
    check_bit(done_o, 1'b0, "R2 done stays low without start");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 pending results: actual %0d expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule